// File: doc/BRIEF.md
# Receive Packet Store with Descriptor Ring

This block holds received packets until a host consumes them. A byte stream with start and end markers fills a 4096-byte circular data memory. Each packet is placed straight after the previous one, at the write pointer. A ring of eight descriptor slots records where each packet starts, how long it is, and the status that arrives with its last byte: receive class, CRC error and incomplete flag. The descriptor for the packet being stored is claimed when its first byte arrives. Slots are claimed in circular order 0..7.

The host reads the oldest stored packet, called the current packet, one byte per request. The read pointer moves forward on its own. When the host has finished with the packet, it either releases it or skips the bytes it has not read. Either command frees the slot and moves on to the next slot in the ring. A packet is dropped, and a full pulse is raised, in two cases:
- all eight slots are in use when the packet starts;
- the data memory runs out of room while the packet is being stored.

A single-cycle pulse marks each completed packet. A debug port reads any slot by index.

Write state machine:
- `W_IDLE` waits for a start byte.
  - It goes to `W_STORE` when a slot is claimed.
  - It goes to `W_DROP` when the start byte is refused.
  - It stays in `W_IDLE` for a stored or refused packet that is one byte long.
- `W_STORE` writes bytes.
  - It returns to `W_IDLE` on the end byte (commit).
  - It goes to `W_DROP` when the memory is full (cancel).
- `W_DROP` ignores bytes and goes to `W_IDLE` on the end byte.

Read state machine:
- `RD_WAIT` goes to `RD_PKT` once the current slot holds a completed packet.
- `RD_PKT` serves reads and returns to `RD_WAIT` on a release or a skip.

Top module: `rx_pkt_store`

## Requirements
- R1: Each stored byte is written at the write pointer, which then advances modulo 4096. A packet that crosses the end of the memory reads back in order, and the next packet starts at (start + length) mod 4096.
- R2: Packets take descriptor slots in circular order (0..7, then 0). The first packet after reset uses slot 0. `cur_slot` moves only by +1 (mod 8), and the recorded start address equals the write pointer at the first byte.
- R3: If all eight slots are valid when a start byte arrives, the whole packet is discarded. `irq_full` pulses, `irq_pkt_rcvd` does not, and no descriptor changes. The two interrupts never pulse in the same cycle.
- R4: `irq_pkt_rcvd` is high for exactly one cycle, the cycle right after the end byte is accepted. `cur_valid` for that packet (when it is the current one) rises one cycle later.
- R5: A descriptor holds the start address, the length in bytes (1 to 4096), and a 4-bit info field sampled with the end byte. Bit 3 is incomplete, bit 2 is CRC error, and bits 1:0 are the class (0 unicast, 1 multicast, 2 broadcast). A one-byte packet (start and end on the same byte) is stored with length 1.
- R6: While `cur_valid` is high and unread bytes remain, `rd_req` returns the byte at the read pointer on `rd_data` one cycle later and advances the pointer. Once the whole packet is read, further requests return 0 and the pointer stays put.
- R7: `cmd_release` after every byte has been read frees the slot and moves `cur_slot` on by one. `cmd_release` while bytes remain unread is ignored: the slot, `cur_valid` and the read position are unchanged. A request in the same cycle as a command is ignored.
- R8: `cmd_skip` frees the slot whether or not bytes remain unread. It moves the read pointer to the end of the packet, so the next packet is read from its first byte.
- R9: For any index on `dbg_idx`, the debug outputs show that slot's valid bit, start address, length and info. When `dbg_idx` equals `cur_slot` and `cur_valid` is high, they match the current-packet outputs.
- R10: If a byte arrives while 4096 bytes are held (unreleased plus in progress), the packet is dropped and its slot is freed. `irq_full` pulses, and the next packet is stored from the dropped packet's start address.
- R11: Reset clears every valid bit, both pointers and `cur_slot`. While `cur_valid` is low, requests return 0 and the read pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Received byte present |
| wr_sop | input | 1 | Byte is the first of a packet |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_data | input | 8 | Received byte |
| wr_class | input | 2 | Packet class, sampled with the last byte |
| wr_crc_err | input | 1 | CRC error flag, sampled with the last byte |
| wr_incomplete | input | 1 | Incomplete-packet flag, sampled with the last byte |
| rd_req | input | 1 | Host byte read request |
| rd_data | output | 8 | Byte returned one cycle after a request, or 0 |
| cmd_release | input | 1 | Release the fully read current packet |
| cmd_skip | input | 1 | Discard the rest of the current packet |
| irq_pkt_rcvd | output | 1 | Pulse: packet stored |
| irq_full | output | 1 | Pulse: packet dropped for lack of slot or room |
| cur_valid | output | 1 | A current packet is available |
| cur_slot | output | 3 | Current slot index |
| cur_addr | output | 12 | Current packet start address |
| cur_len | output | 13 | Current packet length |
| cur_info | output | 4 | Current packet info field |
| dbg_idx | input | 3 | Debug slot select |
| dbg_valid | output | 1 | Selected slot valid bit |
| dbg_addr | output | 12 | Selected slot start address |
| dbg_len | output | 13 | Selected slot length |
| dbg_info | output | 4 | Selected slot info field |

## Verification
The storage path is driven with five kinds of packet:
- short packets carrying different info values, to separate the descriptor fields from one another;
- a one-byte packet, to expose a start/end coincidence bug;
- a run of eight packets that fills the ring and shows that slots are claimed in the right order;
- a large packet followed by one that overruns the memory, to check the tail rewind after a drop;
- a packet that crosses the end of the memory, to catch a pointer that fails to wrap.

The read side is tried with three endings:
- a full read then a release;
- a partial read then a release, which must be ignored;
- a partial read then a skip.

Together these tell a correct read-pointer jump apart from a jump that reads stale or shifted bytes.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    typedef enum logic [1:0] {W_IDLE, W_STORE, W_DROP} wr_state_t;
    typedef enum logic {RD_WAIT, RD_PKT} rd_state_t;
    localparam int INFO_W = 4;
endpackage

// File: rtl/rxb_data_ram.sv
module rxb_data_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rxb_desc_table.sv
module rxb_desc_table #(
    parameter int SLOTS = 8,
    parameter int AW    = 12,
    parameter int LW    = 13,
    parameter int IW    = 4,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic [SW-1:0]    claim_idx,
    input  logic [AW-1:0]    claim_addr,
    input  logic             commit,
    input  logic [SW-1:0]    commit_idx,
    input  logic [LW-1:0]    commit_len,
    input  logic [IW-1:0]    commit_info,
    input  logic             cancel,
    input  logic [SW-1:0]    cancel_idx,
    input  logic             free,
    input  logic [SW-1:0]    free_idx,
    input  logic [SW-1:0]    cur_idx,
    input  logic [SW-1:0]    dbg_idx,
    output logic [SLOTS-1:0] valid_vec,
    output logic             cur_ready,
    output logic [AW-1:0]    cur_addr,
    output logic [LW-1:0]    cur_len,
    output logic [IW-1:0]    cur_info,
    output logic             dbg_valid,
    output logic [AW-1:0]    dbg_addr,
    output logic [LW-1:0]    dbg_len,
    output logic [IW-1:0]    dbg_info
);
    logic [SLOTS-1:0] valid_q;
    logic [SLOTS-1:0] done_q;
    logic [SLOTS-1:0] ready_vec;
    logic [AW-1:0]    addr_a [SLOTS];
    logic [LW-1:0]    len_a  [SLOTS];
    logic [IW-1:0]    info_a [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            done_q  <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                addr_a[i] <= '0;
                len_a[i]  <= '0;
                info_a[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (claim && claim_idx == SW'(i)) begin
                    valid_q[i] <= 1'b1;
                    done_q[i]  <= 1'b0;
                    addr_a[i]  <= claim_addr;
                end
                if (commit && commit_idx == SW'(i)) begin
                    done_q[i] <= 1'b1;
                    len_a[i]  <= commit_len;
                    info_a[i] <= commit_info;
                end
                if ((cancel && cancel_idx == SW'(i)) || (free && free_idx == SW'(i))) begin
                    valid_q[i] <= 1'b0;
                    done_q[i]  <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_ready
        assign ready_vec[g] = valid_q[g] & done_q[g];
    end

    assign valid_vec = valid_q;
    assign cur_ready = ready_vec[cur_idx];
    assign cur_addr  = addr_a[cur_idx];
    assign cur_len   = len_a[cur_idx];
    assign cur_info  = info_a[cur_idx];
    assign dbg_valid = valid_q[dbg_idx];
    assign dbg_addr  = addr_a[dbg_idx];
    assign dbg_len   = len_a[dbg_idx];
    assign dbg_info  = info_a[dbg_idx];
endmodule

// File: rtl/rxb_wr_ctrl.sv
module rxb_wr_ctrl
    import rxb_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 8,
    parameter int SLOTS = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int LW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [DW-1:0]     wr_data,
    input  logic [INFO_W-1:0] wr_info,
    input  logic [SLOTS-1:0]  slot_valid,
    input  logic              mem_full,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DW-1:0]     mem_wdata,
    output logic              claim,
    output logic              commit,
    output logic              cancel,
    output logic [SW-1:0]     wr_slot,
    output logic [AW-1:0]     claim_addr,
    output logic [LW-1:0]     commit_len,
    output logic [INFO_W-1:0] commit_info,
    output logic [LW-1:0]     drop_bytes,
    output logic              irq_pkt,
    output logic              irq_full
);
    wr_state_t     st, nxt;
    logic          store, full_evt;
    logic [AW-1:0] tail, pkt_start;
    logic [LW-1:0] wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        claim    = 1'b0;
        store    = 1'b0;
        commit   = 1'b0;
        cancel   = 1'b0;
        full_evt = 1'b0;
        unique case (st)
            W_IDLE: begin
                if (wr_valid && wr_sop) begin
                    if (slot_valid[wr_slot] || mem_full) begin
                        full_evt = 1'b1;
                        nxt      = wr_eop ? W_IDLE : W_DROP;
                    end else begin
                        claim = 1'b1;
                        store = 1'b1;
                        if (wr_eop) commit = 1'b1;
                        else        nxt    = W_STORE;
                    end
                end
            end
            W_STORE: begin
                if (wr_valid) begin
                    if (mem_full) begin
                        cancel   = 1'b1;
                        full_evt = 1'b1;
                        nxt      = wr_eop ? W_IDLE : W_DROP;
                    end else begin
                        store = 1'b1;
                        if (wr_eop) begin
                            commit = 1'b1;
                            nxt    = W_IDLE;
                        end
                    end
                end
            end
            W_DROP: begin
                if (wr_valid && wr_eop) nxt = W_IDLE;
            end
            default: nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail      <= '0;
            pkt_start <= '0;
            wr_cnt    <= '0;
            wr_slot   <= '0;
            irq_pkt   <= 1'b0;
            irq_full  <= 1'b0;
        end else begin
            irq_pkt  <= commit;
            irq_full <= full_evt;
            if (store) tail <= tail + AW'(1);
            if (cancel) tail <= pkt_start;
            if (claim) begin
                pkt_start <= tail;
                wr_cnt    <= LW'(1);
            end else if (store) begin
                wr_cnt <= wr_cnt + LW'(1);
            end
            if (commit) wr_slot <= wr_slot + SW'(1);
        end
    end

    assign mem_we      = store;
    assign mem_waddr   = tail;
    assign mem_wdata   = wr_data;
    assign claim_addr  = tail;
    assign commit_len  = claim ? LW'(1) : wr_cnt + LW'(1);
    assign commit_info = wr_info;
    assign drop_bytes  = cancel ? wr_cnt : '0;
endmodule

// File: rtl/rxb_rd_ctrl.sv
module rxb_rd_ctrl
    import rxb_pkg::*;
#(
    parameter int AW    = 12,
    parameter int SLOTS = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cur_ready,
    input  logic [AW-1:0] cur_addr,
    input  logic [LW-1:0] cur_len,
    input  logic          rd_req,
    input  logic          cmd_release,
    input  logic          cmd_skip,
    output logic [AW-1:0] head,
    output logic          mem_re,
    output logic [SW-1:0] rd_slot,
    output logic          free,
    output logic          rd_ok,
    output logic [LW-1:0] fill_dec,
    output logic          in_pkt
);
    rd_state_t     st, nxt;
    logic [LW-1:0] rd_cnt, unread;
    logic          do_read;

    assign unread = cur_len - rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_WAIT;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        do_read  = 1'b0;
        free     = 1'b0;
        fill_dec = '0;
        unique case (st)
            RD_WAIT: begin
                if (cur_ready) nxt = RD_PKT;
            end
            RD_PKT: begin
                if (cmd_skip || (cmd_release && unread == '0)) begin
                    free     = 1'b1;
                    fill_dec = unread;
                    nxt      = RD_WAIT;
                end else if (rd_req && !cmd_release && unread != '0) begin
                    do_read  = 1'b1;
                    fill_dec = LW'(1);
                end
            end
            default: nxt = RD_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head    <= '0;
            rd_cnt  <= '0;
            rd_slot <= '0;
            rd_ok   <= 1'b0;
        end else begin
            rd_ok <= do_read;
            if (do_read) begin
                head   <= head + AW'(1);
                rd_cnt <= rd_cnt + LW'(1);
            end else if (free) begin
                head    <= cur_addr + cur_len[AW-1:0];
                rd_cnt  <= '0;
                rd_slot <= rd_slot + SW'(1);
            end
        end
    end

    assign mem_re = do_read;
    assign in_pkt = (st == RD_PKT);
endmodule

// File: rtl/rx_pkt_store.sv
module rx_pkt_store
    import rxb_pkg::*;
#(
    parameter int AW    = 12,
    parameter int SLOTS = 8,
    parameter int DW    = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int LW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [DW-1:0]     wr_data,
    input  logic [1:0]        wr_class,
    input  logic              wr_crc_err,
    input  logic              wr_incomplete,
    input  logic              rd_req,
    output logic [DW-1:0]     rd_data,
    input  logic              cmd_release,
    input  logic              cmd_skip,
    output logic              irq_pkt_rcvd,
    output logic              irq_full,
    output logic              cur_valid,
    output logic [SW-1:0]     cur_slot,
    output logic [AW-1:0]     cur_addr,
    output logic [LW-1:0]     cur_len,
    output logic [INFO_W-1:0] cur_info,
    input  logic [SW-1:0]     dbg_idx,
    output logic              dbg_valid,
    output logic [AW-1:0]     dbg_addr,
    output logic [LW-1:0]     dbg_len,
    output logic [INFO_W-1:0] dbg_info
);
    localparam int DEPTH = 1 << AW;

    logic              mem_we, mem_re, mem_full;
    logic [AW-1:0]     mem_waddr, head_addr;
    logic [DW-1:0]     mem_wdata, mem_q;
    logic              claim, commit, cancel, free, cur_ready, rd_ok;
    logic [SW-1:0]     wr_slot;
    logic [AW-1:0]     claim_addr;
    logic [LW-1:0]     commit_len, drop_bytes, fill_dec, fill;
    logic [INFO_W-1:0] commit_info;
    logic [SLOTS-1:0]  slot_valid;

    rxb_wr_ctrl #(.AW(AW), .DW(DW), .SLOTS(SLOTS)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_data(wr_data),
        .wr_info({wr_incomplete, wr_crc_err, wr_class}),
        .slot_valid(slot_valid), .mem_full(mem_full),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .claim(claim), .commit(commit), .cancel(cancel), .wr_slot(wr_slot),
        .claim_addr(claim_addr), .commit_len(commit_len), .commit_info(commit_info),
        .drop_bytes(drop_bytes), .irq_pkt(irq_pkt_rcvd), .irq_full(irq_full)
    );

    rxb_desc_table #(.SLOTS(SLOTS), .AW(AW), .LW(LW), .IW(INFO_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .claim(claim), .claim_idx(wr_slot), .claim_addr(claim_addr),
        .commit(commit), .commit_idx(wr_slot), .commit_len(commit_len), .commit_info(commit_info),
        .cancel(cancel), .cancel_idx(wr_slot),
        .free(free), .free_idx(cur_slot),
        .cur_idx(cur_slot), .dbg_idx(dbg_idx),
        .valid_vec(slot_valid), .cur_ready(cur_ready),
        .cur_addr(cur_addr), .cur_len(cur_len), .cur_info(cur_info),
        .dbg_valid(dbg_valid), .dbg_addr(dbg_addr), .dbg_len(dbg_len), .dbg_info(dbg_info)
    );

    rxb_rd_ctrl #(.AW(AW), .SLOTS(SLOTS)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .cur_ready(cur_ready), .cur_addr(cur_addr), .cur_len(cur_len),
        .rd_req(rd_req), .cmd_release(cmd_release), .cmd_skip(cmd_skip),
        .head(head_addr), .mem_re(mem_re), .rd_slot(cur_slot), .free(free),
        .rd_ok(rd_ok), .fill_dec(fill_dec), .in_pkt(cur_valid)
    );

    rxb_data_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(head_addr), .rdata(mem_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill <= '0;
        else        fill <= fill + {{(LW-1){1'b0}}, mem_we} - fill_dec - drop_bytes;
    end

    assign mem_full = (fill == LW'(DEPTH));
    assign rd_data  = rd_ok ? mem_q : '0;
endmodule

// File: rtl/rx_pkt_store_chk.sv
module rx_pkt_store_chk #(
    parameter int AW    = 12,
    parameter int SLOTS = 8,
    parameter int DW    = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int LW   = AW + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic [DW-1:0]    rd_data,
    input logic             cur_valid,
    input logic [SW-1:0]    cur_slot,
    input logic [AW-1:0]    cur_addr,
    input logic [SW-1:0]    dbg_idx,
    input logic             dbg_valid,
    input logic [AW-1:0]    dbg_addr,
    input logic [AW-1:0]    head,
    input logic [LW-1:0]    fill,
    input logic             irq_pkt,
    input logic             irq_full,
    input logic [SLOTS-1:0] slot_valid
);
    localparam int DEPTH = 1 << AW;

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot != $past(cur_slot)) |-> (cur_slot == SW'($past(cur_slot) + 1))); // R2
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pkt && irq_full)); // R3
    AST_PKT_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pkt |-> ($countones(slot_valid) >= 1)); // R4
    AST_DBG_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && dbg_idx == cur_slot) |-> (dbg_valid && dbg_addr == cur_addr)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LW'(DEPTH)); // R10
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !cur_valid) |=> (rd_data == '0)); // R11
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_valid |=> (head == $past(head))); // R11
endmodule

bind rx_pkt_store rx_pkt_store_chk #(.AW(AW), .SLOTS(SLOTS), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_data(rd_data),
    .cur_valid(cur_valid), .cur_slot(cur_slot), .cur_addr(cur_addr),
    .dbg_idx(dbg_idx), .dbg_valid(dbg_valid), .dbg_addr(dbg_addr),
    .head(head_addr), .fill(fill), .irq_pkt(irq_pkt_rcvd), .irq_full(irq_full),
    .slot_valid(slot_valid)
);

// File: tb/rx_pkt_store_tb.sv
module rx_pkt_store_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 0, wr_sop = 0, wr_eop = 0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  wr_class = '0;
    logic        wr_crc_err = 0, wr_incomplete = 0;
    logic        rd_req = 0, cmd_release = 0, cmd_skip = 0;
    logic [7:0]  rd_data;
    logic        irq_pkt_rcvd, irq_full, cur_valid, dbg_valid;
    logic [2:0]  cur_slot, dbg_idx = '0;
    logic [11:0] cur_addr, dbg_addr;
    logic [12:0] cur_len, dbg_len;
    logic [3:0]  cur_info, dbg_info;

    int checks = 0, errors = 0, n_pkt = 0, n_full = 0;

    always #4 clk = ~clk;

    rx_pkt_store u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_data(wr_data), .wr_class(wr_class), .wr_crc_err(wr_crc_err),
        .wr_incomplete(wr_incomplete), .rd_req(rd_req), .rd_data(rd_data),
        .cmd_release(cmd_release), .cmd_skip(cmd_skip), .irq_pkt_rcvd(irq_pkt_rcvd),
        .irq_full(irq_full), .cur_valid(cur_valid), .cur_slot(cur_slot),
        .cur_addr(cur_addr), .cur_len(cur_len), .cur_info(cur_info), .dbg_idx(dbg_idx),
        .dbg_valid(dbg_valid), .dbg_addr(dbg_addr), .dbg_len(dbg_len), .dbg_info(dbg_info)
    );

    always @(negedge clk) begin
        if (irq_pkt_rcvd) n_pkt++;
        if (irq_full)     n_full++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    task automatic send_pkt(input int len, input int seed, input logic [3:0] info,
                            input bit expect_store, input string req);
        int p0, f0;
        p0 = n_pkt;
        f0 = n_full;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_valid = 1; wr_sop = (i == 0); wr_eop = (i == len - 1);
            wr_data = 8'(seed + i);
            {wr_incomplete, wr_crc_err, wr_class} = info;
        end
        @(negedge clk);
        wr_valid = 0; wr_sop = 0; wr_eop = 0;
        if (expect_store) chk(irq_pkt_rcvd == 1, "R4", "pkt pulse after last byte", int'(irq_pkt_rcvd), 1);
        @(negedge clk);
        if (expect_store) chk(irq_pkt_rcvd == 0, "R4", "pkt pulse one cycle", int'(irq_pkt_rcvd), 0);
        chk(n_pkt - p0 == (expect_store ? 1 : 0), req, "pkt irq count", n_pkt - p0, expect_store ? 1 : 0);
        chk(n_full - f0 == (expect_store ? 0 : 1), req, "full irq count", n_full - f0, expect_store ? 0 : 1);
    endtask

    task automatic read_byte(output logic [7:0] d);
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
        d = rd_data;
    endtask

    task automatic command(input bit skip);
        @(negedge clk);
        if (skip) cmd_skip = 1; else cmd_release = 1;
        @(negedge clk);
        cmd_skip = 0; cmd_release = 0;
        @(negedge clk);
    endtask

    task automatic read_pkt(input int len, input int seed, input string req);
        logic [7:0] d;
        int bad;
        bad = 0;
        for (int i = 0; i < len; i++) begin
            read_byte(d);
            if (d != 8'(seed + i)) bad++;
        end
        chk(bad == 0, req, "byte mismatches in packet", bad, 0);
    endtask

    task automatic check_cur(input int slot, input int addr, input int len, input int info, input string req);
        chk(cur_valid == 1, req, "cur_valid", int'(cur_valid), 1);
        chk(cur_slot == 3'(slot), req, "cur_slot", int'(cur_slot), slot);
        chk(cur_addr == 12'(addr), req, "cur_addr", int'(cur_addr), addr);
        chk(cur_len == 13'(len), req, "cur_len", int'(cur_len), len);
        chk(cur_info == 4'(info), req, "cur_info", int'(cur_info), info);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int nv;
        nv = 0;
        chk(cur_valid == 0, "R11", "cur_valid after reset", int'(cur_valid), 0);
        chk(cur_slot == 0, "R11", "cur_slot after reset", int'(cur_slot), 0);
        for (int s = 0; s < 8; s++) begin
            dbg_idx = 3'(s); #1;
            if (dbg_valid) nv++;
        end
        chk(nv == 0, "R11", "valid slots after reset", nv, 0);
        read_byte(d);
        chk(d == 0, "R11", "read with no packet", int'(d), 0);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        send_pkt(5, 8'h10, 4'b0000, 1, "R4");
        check_cur(0, 0, 5, 0, "R5");
        read_pkt(5, 8'h10, "R6");
        read_byte(d);
        chk(d == 0, "R6", "read past end", int'(d), 0);
        chk(cur_valid == 1, "R6", "still current after over-read", int'(cur_valid), 1);
        command(0);
        chk(cur_slot == 1 && cur_valid == 0, "R7", "release after full read slot", int'(cur_slot), 1);
        dbg_idx = 3'd0; #1;
        chk(dbg_valid == 0, "R7", "slot0 freed", int'(dbg_valid), 0);
    endtask

    task automatic t_release_ignored();
        logic [7:0] d;
        send_pkt(4, 8'h40, 4'b0101, 1, "R4");
        check_cur(1, 5, 4, 5, "R5");
        read_pkt(2, 8'h40, "R6");
        command(0);
        chk(cur_slot == 1 && cur_valid == 1, "R7", "early release ignored slot", int'(cur_slot), 1);
        read_byte(d);
        chk(d == 8'h42, "R7", "read position kept after ignored release", int'(d), 'h42);
        command(1);
        chk(cur_slot == 2 && cur_valid == 0, "R8", "skip frees slot", int'(cur_slot), 2);
    endtask

    task automatic t_skip_next();
        logic [7:0] d;
        send_pkt(6, 8'h60, 4'b0000, 1, "R4");
        send_pkt(3, 8'h90, 4'b1110, 1, "R4");
        check_cur(2, 9, 6, 0, "R2");
        read_byte(d);
        chk(d == 8'h60, "R6", "first byte", int'(d), 'h60);
        command(1);
        check_cur(3, 15, 3, 'he, "R8");
        read_pkt(3, 8'h90, "R8");
        command(0);
        chk(cur_slot == 4 && cur_valid == 0, "R7", "release advances slot", int'(cur_slot), 4);
    endtask

    task automatic t_single_byte();
        logic [7:0] d;
        send_pkt(1, 8'hA5, 4'b0010, 1, "R5");
        check_cur(4, 18, 1, 2, "R5");
        read_byte(d);
        chk(d == 8'hA5, "R5", "single byte data", int'(d), 'hA5);
        command(0);
        chk(cur_slot == 5, "R7", "slot after single byte", int'(cur_slot), 5);
    endtask

    task automatic t_ring_full();
        int bad, s;
        for (int k = 0; k < 8; k++) send_pkt(2, k * 16, 4'b0001, 1, "R2");
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            dbg_idx = 3'((5 + k) % 8); #1;
            if (!dbg_valid || dbg_addr != 12'(19 + 2 * k) || dbg_len != 13'd2 || dbg_info != 4'd1) bad++;
        end
        chk(bad == 0, "R9", "debug view of full ring", bad, 0);
        send_pkt(3, 8'hEE, 4'b0000, 0, "R3");
        check_cur(5, 19, 2, 1, "R3");
        dbg_idx = 3'd5; #1;
        chk(dbg_addr == 12'd19 && dbg_len == 13'd2, "R3", "slot untouched by dropped packet", int'(dbg_addr), 19);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            s = (5 + k) % 8;
            if (!cur_valid || cur_slot != 3'(s) || cur_addr != 12'(19 + 2 * k)) bad++;
            command(1);
        end
        chk(bad == 0, "R2", "circular consumption order", bad, 0);
        chk(cur_valid == 0, "R3", "dropped packet not stored", int'(cur_valid), 0);
    endtask

    task automatic t_mem_room();
        send_pkt(3000, 8'h11, 4'b0000, 1, "R10");
        send_pkt(2000, 8'h22, 4'b0000, 0, "R10");
        send_pkt(10, 8'h33, 4'b0000, 1, "R10");
        dbg_idx = 3'd6; #1;
        chk(dbg_valid && dbg_addr == 12'd3035 && dbg_len == 13'd10, "R10", "tail rewound after drop", int'(dbg_addr), 3035);
        dbg_idx = 3'd7; #1;
        chk(dbg_valid == 0, "R10", "dropped slot released", int'(dbg_valid), 0);
        check_cur(5, 35, 3000, 0, "R10");
        command(1);
        check_cur(6, 3035, 10, 0, "R8");
        read_pkt(10, 8'h33, "R10");
        command(0);
    endtask

    task automatic t_wrap();
        send_pkt(1100, 8'h77, 4'b0000, 1, "R1");
        check_cur(7, 3045, 1100, 0, "R1");
        read_pkt(1100, 8'h77, "R1");
        command(0);
        send_pkt(2, 8'h55, 4'b0000, 1, "R1");
        check_cur(0, 49, 2, 0, "R1");
        read_pkt(2, 8'h55, "R1");
        command(0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_release_ignored();
        t_skip_next();
        t_single_byte();
        t_ring_full();
        t_mem_room();
        t_wrap();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule